// File: doc/BRIEF.md
# Sweep Pass-Window Locator

This block takes the outcome of a delay sweep, one pass/fail verdict per delay step, and finds the widest stretch of consecutive passing steps. The sweep covers two clock periods in equal steps starting at zero delay, so a step index is also a delay in step units. When the verdict marked as last arrives, the block reports three things about the widest stretch. The first is its midpoint, in half-step units. The second is its width, which is its last index minus its first index. The third is a status code, which flags a sweep with no passing step or a window narrower than a quarter clock period.

The midpoint is then compared against a reference delay. If the midpoint lies one full clock period or more past the reference, it is moved back by one period and a slip flag is raised. This keeps the chosen delay within one cycle of the reference. Verdicts enter through a valid/ready stream. The block applies back-pressure for exactly one cycle per sweep: the cycle in which it presents its result. An upstream source must hold valid, the pass bit and the last flag steady until ready is seen high at a clock edge.

Top module: `pass_window_finder`

## Requirements
- R1: `res_ready` is high in every cycle except the one in which `done` is high. A verdict is consumed only at a clock edge where `res_valid` and `res_ready` are both high.
- R2: `done` is high for exactly one cycle, in the cycle right after the edge that consumes a verdict with `res_last` set.
- R3: Among the closed runs of passes, the longest one is reported. A later run replaces the stored one only when it is strictly longer, so the earliest of equal-length runs is kept.
- R4: A run still open when the last verdict arrives competes on equal terms, so a run reaching the top of the sweep can win.
- R5: If no verdict in the sweep passes, `status` is 2'b01 and `centre_hs`, `win_len` and `slip` are all zero.
- R6: For the reported run from index s to index e, `win_len` = e − s and `centre_hs` = s + e before any fold. The LSB of `centre_hs` weighs half a step.
- R7: With a run found, `status` is 2'b10 when 4·`win_len` < `PERIOD_STEPS`, and 2'b00 otherwise. For the defaults, a width of 12 is narrow and a width of 13 is accepted.
- R8: If the unfolded centre is greater than or equal to `ref_hs` + 2·`PERIOD_STEPS` (all in half-steps, equality included), `slip` is 1 and `centre_hs` is reduced by 2·`PERIOD_STEPS`. Otherwise `slip` is 0. `ref_hs` is sampled at the edge that consumes the last verdict.
- R9: After reset, `done` and `slip` are 0, `centre_hs` and `win_len` are 0, `status` is 2'b00 and `res_ready` is 1. The result outputs hold their values until the next sweep completes.
- R10: The k-th verdict consumed since the previous last verdict has step index k, counting from 0. Cycles with `res_valid` low do not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Verdict stream valid |
| res_ready | output | 1 | Verdict stream ready |
| res_pass | input | 1 | 1 = this delay step passed |
| res_last | input | 1 | Marks the final verdict of a sweep |
| ref_hs | input | $clog2(N_STEPS)+1 | Reference delay in half-steps |
| done | output | 1 | One-cycle pulse, result valid |
| status | output | 2 | 00 ok, 01 no passing step, 10 too narrow |
| centre_hs | output | $clog2(N_STEPS)+1 | Window midpoint in half-steps, after fold |
| win_len | output | $clog2(N_STEPS) | Window width in steps |
| slip | output | 1 | Centre was folded back by one period |

## Verification
The hardest case to create is a sweep in which two runs compete at the moment the last verdict arrives, because the open run and the stored best are compared in that same cycle. The stimulus builds several such sweeps. In one, a short early run loses to a run that ends at index 99. In another, equal-width runs tie and the earlier one must win. A further sweep inserts valid-low gaps to show that stalls do not shift indices. The fold boundary is reached by choosing `ref_hs` so that the unfolded centre lands exactly on, and one half-step below, the threshold.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  typedef enum logic [1:0] {
    PWF_OK     = 2'b00,
    PWF_NONE   = 2'b01,
    PWF_NARROW = 2'b10
  } pwf_status_e;
endpackage

// File: rtl/pwf_run_tracker.sv
module pwf_run_tracker #(
  parameter int N_STEPS = 100,
  parameter int IDX_W   = $clog2(N_STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             pass,
  input  logic             last,
  output logic             fin_found,
  output logic [IDX_W-1:0] fin_start,
  output logic [IDX_W-1:0] fin_end
);
  logic [IDX_W-1:0] idx, cur_start, best_start, best_end;
  logic             cur_open, best_valid;
  logic             close_fail, close_last, take;
  logic [IDX_W-1:0] cand_s, cand_e, cand_len, best_len;

  assign best_len   = best_end - best_start;
  assign close_fail = acc && !pass && cur_open;
  assign close_last = acc && pass && last;

  always_comb begin
    if (close_last) begin
      cand_s = cur_open ? cur_start : idx;
      cand_e = idx;
    end else begin
      cand_s = cur_start;
      cand_e = idx - IDX_W'(1);
    end
    cand_len = cand_e - cand_s;
    take     = (close_fail || close_last) && (!best_valid || (cand_len > best_len));
    fin_found = best_valid || take;
    fin_start = take ? cand_s : best_start;
    fin_end   = take ? cand_e : best_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      cur_open   <= 1'b0;
      cur_start  <= '0;
      best_valid <= 1'b0;
      best_start <= '0;
      best_end   <= '0;
    end else if (acc) begin
      if (last) begin
        idx        <= '0;
        cur_open   <= 1'b0;
        best_valid <= 1'b0;
      end else begin
        idx <= idx + IDX_W'(1);
        if (pass) begin
          if (!cur_open) begin
            cur_open  <= 1'b1;
            cur_start <= idx;
          end
        end else begin
          cur_open <= 1'b0;
        end
        best_valid <= fin_found;
        best_start <= fin_start;
        best_end   <= fin_end;
      end
    end
  end

  AST_BEST_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && !(acc && last)) |=> (best_len >= $past(best_len))); // R3

  AST_IDX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(idx)); // R10

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (idx < IDX_W'(N_STEPS))); // R10

  AST_OPEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cur_open |-> (cur_start <= idx)); // R6
endmodule

// File: rtl/pwf_finalize.sv
module pwf_finalize import pwf_pkg::*; #(
  parameter int N_STEPS      = 100,
  parameter int PERIOD_STEPS = 50,
  parameter int IDX_W        = $clog2(N_STEPS)
) (
  input  logic             found,
  input  logic [IDX_W-1:0] win_s,
  input  logic [IDX_W-1:0] win_e,
  input  logic [IDX_W:0]   ref_hs,
  output logic [IDX_W:0]   centre_hs,
  output logic [IDX_W-1:0] win_len,
  output logic             slip,
  output pwf_status_e      status
);
  localparam int CW = IDX_W + 1;
  localparam int XW = IDX_W + 3;
  localparam logic [XW-1:0] TWO_P = XW'(2 * PERIOD_STEPS);
  localparam logic [XW-1:0] ONE_P = XW'(PERIOD_STEPS);

  logic [CW-1:0]    sum_hs;
  logic [XW-1:0]    sum_x, thr_x, len_x4, fold_x;
  logic [IDX_W-1:0] len_raw;

  always_comb begin
    len_raw = win_e - win_s;
    sum_hs  = {1'b0, win_s} + {1'b0, win_e};
    sum_x   = {2'b00, sum_hs};
    thr_x   = {2'b00, ref_hs} + TWO_P;
    len_x4  = {1'b0, len_raw, 2'b00};
    fold_x  = sum_x - TWO_P;
    slip    = found && (sum_x >= thr_x);
    if (!found) begin
      centre_hs = '0;
      win_len   = '0;
      status    = PWF_NONE;
    end else begin
      centre_hs = slip ? fold_x[CW-1:0] : sum_hs;
      win_len   = len_raw;
      status    = (len_x4 < ONE_P) ? PWF_NARROW : PWF_OK;
    end
  end
endmodule

// File: rtl/pass_window_finder.sv
module pass_window_finder import pwf_pkg::*; #(
  parameter int N_STEPS      = 100,
  parameter int PERIOD_STEPS = 50
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       res_valid,
  output logic                       res_ready,
  input  logic                       res_pass,
  input  logic                       res_last,
  input  logic [$clog2(N_STEPS):0]   ref_hs,
  output logic                       done,
  output logic [1:0]                 status,
  output logic [$clog2(N_STEPS):0]   centre_hs,
  output logic [$clog2(N_STEPS)-1:0] win_len,
  output logic                       slip
);
  localparam int IDX_W = $clog2(N_STEPS);
  localparam int CW    = IDX_W + 1;
  localparam int XW    = IDX_W + 3;

  logic             acc, fin_now, fin_found;
  logic [IDX_W-1:0] fin_start, fin_end, f_len;
  logic [CW-1:0]    f_centre;
  logic             f_slip;
  pwf_status_e      f_status;

  assign res_ready = !done;
  assign acc       = res_valid && res_ready;
  assign fin_now   = acc && res_last;

  pwf_run_tracker #(.N_STEPS(N_STEPS), .IDX_W(IDX_W)) trk_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .pass(res_pass), .last(res_last),
    .fin_found(fin_found), .fin_start(fin_start), .fin_end(fin_end)
  );

  pwf_finalize #(.N_STEPS(N_STEPS), .PERIOD_STEPS(PERIOD_STEPS), .IDX_W(IDX_W)) fin_i (
    .found(fin_found), .win_s(fin_start), .win_e(fin_end), .ref_hs(ref_hs),
    .centre_hs(f_centre), .win_len(f_len), .slip(f_slip), .status(f_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      status    <= PWF_OK;
      centre_hs <= '0;
      win_len   <= '0;
      slip      <= 1'b0;
    end else begin
      done <= fin_now;
      if (fin_now) begin
        status    <= f_status;
        centre_hs <= f_centre;
        win_len   <= f_len;
        slip      <= f_slip;
      end
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_last) |=> done); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_NARROW_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == PWF_OK) |-> ({1'b0, win_len, 2'b00} >= XW'(PERIOD_STEPS))); // R7

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == PWF_NONE) |-> (win_len == '0 && centre_hs == '0 && !slip)); // R5

  AST_FOLD_ABOVE_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && slip) |-> ({2'b00, centre_hs} >= {2'b00, $past(ref_hs)})); // R8

  AST_NOFOLD_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !slip && status != PWF_NONE) |->
      ({2'b00, centre_hs} < ({2'b00, $past(ref_hs)} + XW'(2 * PERIOD_STEPS)))); // R8

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fin_now) |-> ($stable(centre_hs) && $stable(win_len) && $stable(slip))); // R9
endmodule

// File: tb/pass_window_finder_tb_top.sv
module pass_window_finder_tb_top;
  localparam int N = 100;
  localparam int P = 50;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       res_valid, res_pass, res_last;
  logic       res_ready, done, slip;
  logic [7:0] ref_hs;
  logic [1:0] status;
  logic [7:0] centre_hs;
  logic [6:0] win_len;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pass_window_finder #(.N_STEPS(N), .PERIOD_STEPS(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_pass(res_pass), .res_last(res_last), .ref_hs(ref_hs), .done(done),
    .status(status), .centre_hs(centre_hs), .win_len(win_len), .slip(slip)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] span(input int lo, input int hi);
    logic [N-1:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Expected results derived from the requirement text
  task automatic model(input logic [N-1:0] m, input int n, input int rv,
                       output int c, output int l, output int s, output int st);
    int bs = -1, be = -1, cs = -1, ce = -1;
    for (int i = 0; i < n; i++) begin
      if (m[i]) begin
        if (cs < 0) cs = i;
        ce = i;
      end else if (cs >= 0) begin
        if (bs < 0 || (ce - cs) > (be - bs)) begin bs = cs; be = ce; end
        cs = -1;
      end
    end
    if (cs >= 0 && (bs < 0 || (ce - cs) > (be - bs))) begin bs = cs; be = ce; end
    if (bs < 0) begin
      c = 0; l = 0; s = 0; st = 1;
    end else begin
      l = be - bs; c = bs + be;
      s = (c >= rv + 2 * P) ? 1 : 0;
      if (s != 0) c = c - 2 * P;
      st = (4 * l < P) ? 2 : 0;
    end
  endtask

  task automatic run_sweep(input logic [N-1:0] m, input int n, input int rv,
                           input int gap, input string req);
    int ec, el, es, est;
    int hc, hl;
    model(m, n, rv, ec, el, es, est);
    ref_hs = 8'(rv);
    for (int i = 0; i < n; i++) begin
      if (gap != 0 && (i % gap) == 1) begin
        res_valid = 1'b0;
        @(negedge clk);
      end
      res_valid = 1'b1;
      res_pass  = m[i];
      res_last  = (i == n - 1);
      @(negedge clk);
    end
    res_valid = 1'b0;
    res_last  = 1'b0;
    chk(done == 1'b1, {req, " R2 done after last"}, int'(done), 1);
    chk(res_ready == 1'b0, {req, " R1 ready low in done cycle"}, int'(res_ready), 0);
    chk(int'(centre_hs) == ec, {req, " R6 centre"}, int'(centre_hs), ec);
    chk(int'(win_len) == el, {req, " R6 length"}, int'(win_len), el);
    chk(int'(slip) == es, {req, " R8 slip"}, int'(slip), es);
    chk(int'(status) == est, {req, " R7 status"}, int'(status), est);
    hc = int'(centre_hs);
    hl = int'(win_len);
    ref_hs = 8'd0;
    @(negedge clk);
    chk(done == 1'b0, {req, " R2 single pulse"}, int'(done), 0);
    chk(res_ready == 1'b1, {req, " R1 ready back"}, int'(res_ready), 1);
    @(negedge clk);
    chk(int'(centre_hs) == hc && int'(win_len) == hl, {req, " R9 hold"}, int'(centre_hs), hc);
  endtask

  task automatic t_reset;
    chk(done == 1'b0 && slip == 1'b0, "R9 reset done/slip", int'(done), 0);
    chk(centre_hs == 8'd0 && win_len == 7'd0, "R9 reset fields", int'(centre_hs), 0);
    chk(status == 2'b00, "R9 reset status", int'(status), 0);
    chk(res_ready == 1'b1, "R1 reset ready", int'(res_ready), 1);
  endtask

  task automatic t_single;   run_sweep(span(20, 40), N, 0, 0, "R6 single run"); endtask
  task automatic t_longer;   run_sweep(span(5, 10) | span(30, 50), N, 0, 0, "R3 longer later"); endtask
  task automatic t_tie;      run_sweep(span(10, 25) | span(50, 65), N, 0, 0, "R3 tie keeps first"); endtask
  task automatic t_open_end; run_sweep(span(0, 5) | span(70, 99), N, 40, 0, "R4 open at end with fold"); endtask
  task automatic t_nofold;   run_sweep(span(70, 99), N, 70, 0, "R8 below threshold"); endtask
  task automatic t_eq_fold;  run_sweep(span(71, 99), N, 70, 0, "R8 equality folds"); endtask
  task automatic t_none;     run_sweep('0, N, 0, 0, "R5 no pass"); endtask
  task automatic t_narrow;   run_sweep(span(10, 22), N, 0, 0, "R7 width 12 narrow"); endtask
  task automatic t_wide13;   run_sweep(span(10, 23), N, 0, 0, "R7 width 13 ok"); endtask
  task automatic t_short;    run_sweep(span(0, 59), 60, 0, 0, "R4 short sweep all pass"); endtask
  task automatic t_stall;
    run_sweep(span(3, 8) | span(12, 40) | span(60, 62), N, 10, 3, "R10 stalls keep index");
  endtask

  initial begin
    res_valid = 1'b0; res_pass = 1'b0; res_last = 1'b0; ref_hs = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_longer();
    t_tie();
    t_open_end();
    t_nofold();
    t_eq_fold();
    t_none();
    t_narrow();
    t_wide13();
    t_short();
    t_stall();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule